// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter

This block is a binary up-counter, four bits wide by default, that can be preset from a parallel data bus. It has an active-low clear, an active-low synchronous load, and two active-high count enables. The counter advances on a rising clock edge only when both enables are high. When the count is at its maximum, a carry output goes high, but only while the second enable is also high. That lets a row of stages be chained into a wider counter: each stage's carry feeds the carry-gating enable of the next stage.

A build parameter chooses how the clear behaves. In one form it resets the count at once, whatever the clock is doing. In the other form it takes effect on the next rising edge. Everything else is identical in both forms.

The priority, from highest to lowest, is clear, then load, then count, then hold. The block has no data stream with flow control. All its pins are plain control, data and status pins, so no valid/ready rules apply. Inputs are assumed settled well before the rising edge that uses them.

Top module: `preset_counter`

## Requirements
- R1: With `ASYNC_CLR=1`, driving `clr_n` low forces `q` to zero without waiting for a clock edge.
- R2: With `ASYNC_CLR=0`, a low `clr_n` leaves `q` unchanged until the next rising edge, and `q` is zero after that edge.
- R3: `load_n` is active low. `q` takes the value of `din` at the rising edge that samples `load_n` low. A falling `load_n` between edges does not change `q`.
- R4: When `clr_n` and `load_n` are high and both `en_p` and `en_t` are high, `q` increments by one at each rising edge.
- R5: When `clr_n` and `load_n` are high and either enable is low, `q` keeps its value across the edge.
- R6: Counting from the all-ones value gives zero. The sequence after a preset of 12 is 13, 14, 15, 0.
- R7: Clear overrides load, and load overrides counting, when they are asserted at the same edge.
- R8: `rco` is high exactly when `q` is all ones and `en_t` is high. `en_p` has no effect on `rco`.
- R9: A load takes effect even when both enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous depending on `ASYNC_CLR` |
| load_n | input | 1 | Active-low synchronous parallel load |
| din | input | WIDTH | Parallel preset value |
| en_p | input | 1 | Count enable; does not affect the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| q | output | WIDTH | Current count |
| rco | output | 1 | Ripple carry: count is all ones and `en_t` is high |

## Verification
Both clear forms run the same stimulus table in parallel. The table covers a preset of 12 followed by counting through the wrap, and all four enable combinations with the count held at a nonzero value. It also drives clear and load together, and load and count together, which separates the three priority levels. A load at the all-ones value followed by toggling `en_p` and `en_t` separates the carry's dependence on `en_t` from its independence of `en_p`. Directed cases then pull clear low and load low between clock edges. The two variants must differ before the edge and agree after it.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_ctrl.sv
// Priority decode of the control pins: clear, load, count, hold.
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output cnt_op_e op
);
  always_comb begin
    if (!clr_n)            op = OP_CLEAR;   // R7: clear wins
    else if (!load_n)      op = OP_LOAD;    // R9: enables ignored
    else if (en_p && en_t) op = OP_COUNT;
    else                   op = OP_HOLD;
  end
endmodule

// File: rtl/cnt_next.sv
// Next-count datapath selected by the decoded operation.
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);
  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = din;
      OP_COUNT: nxt = WIDTH'(cur + 1'b1);   // wraps naturally (R6)
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/cnt_state.sv
// Count register; the clear form is picked by ASYNC_CLR.
module cnt_state #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);
  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
      // R1: while clear is low the register reads zero at every edge
      p_async_clear_r1: assert property (@(posedge clk) !clr_n |-> q == '0);
    end else begin : g_sync
      always_ff @(posedge clk) begin
        q <= nxt;
      end
      // R2: a sampled low clear yields zero after the edge
      p_sync_clear_r2: assert property (@(posedge clk) !clr_n |=> q == '0);
    end
  endgenerate
endmodule

// File: rtl/preset_counter.sv
module preset_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] q,
  output logic             rco
);
  localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

  cnt_op_e          op;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] q_r;

  cnt_ctrl u_ctrl (
    .clr_n (clr_n),
    .load_n(load_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .op    (op)
  );

  cnt_next #(.WIDTH(WIDTH)) u_next (
    .op (op),
    .cur(q_r),
    .din(din),
    .nxt(nxt)
  );

  cnt_state #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_state (
    .clk  (clk),
    .clr_n(clr_n),
    .nxt  (nxt),
    .q    (q_r)
  );

  assign q   = q_r;
  assign rco = en_t & (q_r == TOP_VAL);

  // R3: load captures din at the sampling edge
  p_load_r3: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din));

  // R4: both enables high counts by one
  p_count_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t) |=> q == WIDTH'($past(q) + 1'b1));

  // R5: any enable low holds the count
  p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(q));

  // R6: the all-ones value counts to zero
  p_wrap_r6: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t && q == TOP_VAL) |=> q == '0);

  // R8: carry needs en_t; en_p plays no part
  p_rco_needs_ent_r8: assert property (@(posedge clk) !en_t |-> !rco);
  p_rco_at_top_r8: assert property (@(posedge clk)
    (en_t && q == TOP_VAL) |-> rco);
endmodule

// File: tb/preset_counter_tb.sv
`timescale 1ns/1ps
module preset_counter_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         clr_n, load_n, en_p, en_t;
  logic [W-1:0] din;
  logic [W-1:0] q_a, q_s;
  logic         rco_a, rco_s;
  int           n_tests = 0;
  int           n_fail  = 0;
  bit           done    = 1'b0;

  always #5 clk = ~clk;   // 100 MHz

  preset_counter #(.WIDTH(W), .ASYNC_CLR(1'b1)) u_dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(q_a), .rco(rco_a)
  );

  preset_counter #(.WIDTH(W), .ASYNC_CLR(1'b0)) u_dut_sync (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(q_s), .rco(rco_s)
  );

  // Vector: {clr_n, load_n, din[3:0], en_p, en_t, exp_q[3:0], exp_rco}
  localparam int NV = 16;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 1'b1, 4'd0,  1'b0, 1'b0, 4'd0,  1'b0}, // 0  reset state (R2)
    {1'b1, 1'b0, 4'd12, 1'b0, 1'b0, 4'd12, 1'b0}, // 1  load, enables low (R9)
    {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd13, 1'b0}, // 2  count (R4)
    {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd14, 1'b0}, // 3
    {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd15, 1'b1}, // 4  carry (R8)
    {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  1'b0}, // 5  wrap (R6)
    {1'b1, 1'b1, 4'd0,  1'b0, 1'b1, 4'd0,  1'b0}, // 6  hold (R5)
    {1'b1, 1'b0, 4'd3,  1'b1, 1'b1, 4'd3,  1'b0}, // 7  load over count (R7)
    {1'b1, 1'b1, 4'd0,  1'b1, 1'b0, 4'd3,  1'b0}, // 8  hold en_t low (R5)
    {1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd3,  1'b0}, // 9  hold both low (R5)
    {1'b1, 1'b1, 4'd0,  1'b0, 1'b1, 4'd3,  1'b0}, // 10 hold en_p low (R5)
    {1'b1, 1'b0, 4'd15, 1'b0, 1'b1, 4'd15, 1'b1}, // 11 load top, carry (R8)
    {1'b1, 1'b1, 4'd0,  1'b0, 1'b1, 4'd15, 1'b1}, // 12 en_p low, carry stays (R8)
    {1'b1, 1'b1, 4'd0,  1'b1, 1'b0, 4'd15, 1'b0}, // 13 en_t low kills carry (R8)
    {1'b0, 1'b0, 4'd9,  1'b1, 1'b1, 4'd0,  1'b0}, // 14 clear over load (R7)
    {1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd1,  1'b0}  // 15 count from 0 (R4)
  };

  function automatic string vec_tag(int i);
    case (i)
      0:               return "R2";
      1:               return "R9";
      2, 3, 15:        return "R4";
      5:               return "R6";
      6, 8, 9, 10:     return "R5";
      7, 14:           return "R7";
      default:         return "R8";
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    clr_n = 1'b0; load_n = 1'b1; din = '0; en_p = 1'b0; en_t = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {clr_n, load_n, din, en_p, en_t} = VEC[i][12:5];
      @(posedge clk);
      #2;
      check(vec_tag(i), "q async", int'(q_a), int'(VEC[i][4:1]));
      check(vec_tag(i), "q sync",  int'(q_s), int'(VEC[i][4:1]));
      check(vec_tag(i), "rco async", int'(rco_a), int'(VEC[i][0]));
      check(vec_tag(i), "rco sync",  int'(rco_s), int'(VEC[i][0]));
    end

    // Preset 10 with enables low
    @(negedge clk);
    clr_n = 1'b1; load_n = 1'b0; din = 4'd10; en_p = 1'b0; en_t = 1'b0;
    @(posedge clk); #2;
    check("R9", "preset q", int'(q_s), 10);

    // R1/R2: clear pulled low mid-cycle
    @(negedge clk);
    load_n = 1'b1;
    #1 clr_n = 1'b0;
    #1;
    check("R1", "async clear before edge", int'(q_a), 0);
    check("R2", "sync clear before edge", int'(q_s), 10);
    @(posedge clk); #2;
    check("R2", "sync clear after edge", int'(q_s), 0);
    check("R1", "async clear after edge", int'(q_a), 0);

    // R3: load falls mid-cycle, captured only at the edge
    @(negedge clk);
    clr_n = 1'b1;
    #1 load_n = 1'b0; din = 4'd7;
    #2;
    check("R3", "q before load edge async", int'(q_a), 0);
    check("R3", "q before load edge sync",  int'(q_s), 0);
    @(posedge clk); #2;
    check("R3", "q after load edge async", int'(q_a), 7);
    check("R3", "q after load edge sync",  int'(q_s), 7);

    // R4: one more count from the loaded value
    @(negedge clk);
    load_n = 1'b1; en_p = 1'b1; en_t = 1'b1;
    @(posedge clk); #2;
    check("R4", "count from 7", int'(q_a), 8);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule